// File: doc/BRIEF.md
# Triple-key pass sequencer

This block turns a cipher core that handles one 64-bit block in one pass into a three-pass composite cipher. On a start pulse it captures the data block, up to three 64-bit keys, the overall direction and the key-count mode. It then runs the core three times in a row. For each pass it picks the key and the core direction. The outer passes go in the requested direction and the middle pass goes the opposite way. The result of each pass becomes the input of the next.

The core sits behind a small request/response handshake. A one-cycle request is issued together with the key, the direction flag and the data word. The sequencer then waits, however long it takes, for the core's response-valid strobe before it moves on. When the third response arrives, the final word is stored in a result register and a one-cycle done pulse is raised. With one key the three passes collapse into a single pass. With two keys the first key is used for the outer passes and the second for the middle pass.

Top module: `tkey_pass_seq`

## Requirements
- R1: After a synchronous reset, done_o, core_req_o and result_o are all zero.
- R2: Each accepted start produces exactly three core requests. Each request is high for one cycle only, and a new request is issued only after the response to the previous one.
- R3: For decrypt_i, 0 means encrypt and 1 means decrypt; core_dec_o uses the same encoding. Passes 0 and 2 run in the captured direction and pass 1 runs in the opposite direction.
- R4: Three-key mode is key_mode_i = 2'b10 or 2'b11. Encryption uses key1, key2, key3 for passes 0, 1, 2; decryption uses key3, key2, key1.
- R5: Two-key mode is key_mode_i = 2'b01. Passes 0 and 2 use key1 and pass 1 uses key2, in both directions.
- R6: One-key mode is key_mode_i = 2'b00. All three passes use key1, so the result equals one core pass under key1 in the requested direction.
- R7: Pass 0 receives the data_i value captured at start. Each later pass receives the previous pass's response word, and the third response becomes result_o.
- R8: done_o is high for exactly one cycle, in the cycle after the third response is accepted. result_o changes only in that cycle and holds its value at all other times.
- R9: A start pulse while a block is in progress is ignored. Changes to the keys, mode, direction or data inputs after the start is accepted do not affect the block in progress.
- R10: A response-valid strobe while no pass is outstanding is ignored. It does not change result_o and does not raise done_o.
- R11: core_key_o, core_dec_o and core_data_o stay constant from a request until its response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse for one block |
| decrypt_i | input | 1 | Overall direction, 1 = decrypt |
| key_mode_i | input | 2 | Key-count mode: 00 one key, 01 two keys, 1x three keys |
| key1_i | input | 64 | First key |
| key2_i | input | 64 | Second key |
| key3_i | input | 64 | Third key |
| data_i | input | 64 | Data block captured at start |
| core_req_o | output | 1 | One-cycle pass request to the core |
| core_dec_o | output | 1 | Pass direction to the core, 1 = decrypt |
| core_key_o | output | 64 | Key for the current pass |
| core_data_o | output | 64 | Input word for the current pass |
| core_rsp_valid_i | input | 1 | Core response strobe |
| core_rsp_data_i | input | 64 | Core response word |
| result_o | output | 64 | Final result, held between blocks |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The stand-in core responds after one, two or three cycles, so every pass is checked under a different wait length. A sequencer that advanced on a fixed delay would fail those checks with early requests or wrong data. Each mode is run in both directions and round-tripped. If the key order were not reversed for three-key decryption, or the middle-pass direction were not flipped, the decrypted result would not match the original block. A second start in the middle of a run, together with changed inputs, exposes a design that restarts or picks up the new keys. A stray response strobe while idle exposes one that overwrites the result or raises done without a request.

// File: rtl/tkey_pkg.sv
package tkey_pkg;

    localparam int NUM_PASS = 3;
    localparam int NUM_KEYS = 3;
    localparam int PASS_W   = 2;

    typedef enum logic [1:0] {
        KM_ONE   = 2'b00,
        KM_TWO   = 2'b01,
        KM_THREE = 2'b10,
        KM_TRIO  = 2'b11
    } key_mode_e;

    typedef enum logic [1:0] {
        KSEL_1 = 2'd0,
        KSEL_2 = 2'd1,
        KSEL_3 = 2'd2
    } key_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic      dec;
        key_mode_e mode;
    } run_cfg_t;

    typedef struct packed {
        key_sel_e ksel;
        logic     dec;
    } pass_op_t;

    // Choose the key slot and the core direction for one pass.
    function automatic pass_op_t plan_pass(run_cfg_t cfg, logic [PASS_W-1:0] pass);
        pass_op_t op;
        op.dec = cfg.dec ^ (pass == 2'd1);
        unique case (cfg.mode)
            KM_ONE: op.ksel = KSEL_1;
            KM_TWO: op.ksel = (pass == 2'd1) ? KSEL_2 : KSEL_1;
            default: begin
                if (pass == 2'd1)      op.ksel = KSEL_2;
                else if (pass == 2'd0) op.ksel = cfg.dec ? KSEL_3 : KSEL_1;
                else                   op.ksel = cfg.dec ? KSEL_1 : KSEL_3;
            end
        endcase
        return op;
    endfunction

endpackage

// File: rtl/tkey_seq_fsm.sv
module tkey_seq_fsm
    import tkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              decrypt_i,
    input  logic [1:0]        mode_i,
    input  logic              rsp_valid_i,
    output logic              load_o,
    output logic              issue_o,
    output logic              step_o,
    output logic              finish_o,
    output logic              busy_o,
    output logic [PASS_W-1:0] pass_o,
    output run_cfg_t          cfg_o
);

    seq_state_e        state_q, state_d;
    logic [PASS_W-1:0] pass_q;
    run_cfg_t          cfg_q;
    logic              take;
    logic              last;

    assign load_o   = (state_q == ST_IDLE) && start_i;
    assign take     = (state_q == ST_WAIT) && rsp_valid_i;
    assign last     = (pass_q == PASS_W'(NUM_PASS - 1));
    assign step_o   = take && !last;
    assign finish_o = take && last;
    assign issue_o  = (state_q == ST_ISSUE);
    assign busy_o   = (state_q != ST_IDLE);
    assign pass_o   = pass_q;
    assign cfg_o    = cfg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid_i) state_d = last ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                pass_q    <= '0;
                cfg_q.dec <= decrypt_i;
                cfg_q.mode <= key_mode_e'(mode_i);
            end else if (step_o) begin
                pass_q <= pass_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/tkey_key_plan.sv
module tkey_key_plan
    import tkey_pkg::*;
#(
    parameter int KW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [KW-1:0]     key1_i,
    input  logic [KW-1:0]     key2_i,
    input  logic [KW-1:0]     key3_i,
    input  run_cfg_t          cfg_i,
    input  logic [PASS_W-1:0] pass_i,
    output logic [KW-1:0]     key_o,
    output logic              dec_o
);

    logic [NUM_KEYS-1:0][KW-1:0] key_in;
    logic [NUM_KEYS-1:0][KW-1:0] key_bank;
    pass_op_t                    op;

    assign key_in = {key3_i, key2_i, key1_i};

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
        logic [KW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)         slot_q <= '0;
            else if (load_i) slot_q <= key_in[g];
        end
        assign key_bank[g] = slot_q;
    end

    assign op    = plan_pass(cfg_i, pass_i);
    assign key_o = key_bank[op.ksel];
    assign dec_o = op.dec;

endmodule

// File: rtl/tkey_data_path.sv
module tkey_data_path #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          finish_i,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic [DW-1:0] blk_o,
    output logic [DW-1:0] result_o,
    output logic          done_o
);

    logic [DW-1:0] blk_q;
    logic [DW-1:0] result_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (load_i)      blk_q <= data_i;
            else if (step_i) blk_q <= rsp_data_i;
            if (finish_i)    result_q <= rsp_data_i;
        end
    end

    assign blk_o    = blk_q;
    assign result_o = result_q;
    assign done_o   = done_q;

endmodule

// File: rtl/tkey_pass_seq.sv
module tkey_pass_seq
    import tkey_pkg::*;
#(
    parameter int DW = 64,
    parameter int KW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          decrypt_i,
    input  logic [1:0]    key_mode_i,
    input  logic [KW-1:0] key1_i,
    input  logic [KW-1:0] key2_i,
    input  logic [KW-1:0] key3_i,
    input  logic [DW-1:0] data_i,
    output logic          core_req_o,
    output logic          core_dec_o,
    output logic [KW-1:0] core_key_o,
    output logic [DW-1:0] core_data_o,
    input  logic          core_rsp_valid_i,
    input  logic [DW-1:0] core_rsp_data_i,
    output logic [DW-1:0] result_o,
    output logic          done_o
);

    logic              load;
    logic              step;
    logic              finish;
    logic              busy;
    logic [PASS_W-1:0] pass_idx;
    run_cfg_t          run_cfg;
    logic              run_dec;

    assign run_dec = run_cfg.dec;

    tkey_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .decrypt_i  (decrypt_i),
        .mode_i     (key_mode_i),
        .rsp_valid_i(core_rsp_valid_i),
        .load_o     (load),
        .issue_o    (core_req_o),
        .step_o     (step),
        .finish_o   (finish),
        .busy_o     (busy),
        .pass_o     (pass_idx),
        .cfg_o      (run_cfg)
    );

    tkey_key_plan #(.KW(KW)) u_keys (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .key1_i (key1_i),
        .key2_i (key2_i),
        .key3_i (key3_i),
        .cfg_i  (run_cfg),
        .pass_i (pass_idx),
        .key_o  (core_key_o),
        .dec_o  (core_dec_o)
    );

    tkey_data_path #(.DW(DW)) u_data (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .step_i     (step),
        .finish_i   (finish),
        .data_i     (data_i),
        .rsp_data_i (core_rsp_data_i),
        .blk_o      (core_data_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/tkey_pass_seq_chk.sv
module tkey_pass_seq_chk #(
    parameter int DW = 64,
    parameter int KW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          core_req_o,
    input logic          core_dec_o,
    input logic [KW-1:0] core_key_o,
    input logic [DW-1:0] core_data_o,
    input logic          core_rsp_valid_i,
    input logic [DW-1:0] result_o,
    input logic          done_o,
    input logic          busy,
    input logic [1:0]    pass_idx,
    input logic          run_dec
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        core_req_o |=> !core_req_o); // R2
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        core_req_o |-> busy); // R2
    AST_MID_PASS_FLIP: assert property (@(posedge clk) disable iff (rst)
        (core_req_o && pass_idx == 2'd1) |-> (core_dec_o != run_dec)); // R3
    AST_OUTER_PASS_DIR: assert property (@(posedge clk) disable iff (rst)
        (core_req_o && pass_idx != 2'd1) |-> (core_dec_o == run_dec)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (armed && !done_o) |-> $stable(result_o)); // R8
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && !core_rsp_valid_i) |=> ($stable(run_dec) && $stable(pass_idx))); // R9
    AST_IDLE_RSP_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (!busy && core_rsp_valid_i) |=> !done_o); // R10
    AST_OPS_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        core_req_o |=> ($stable(core_key_o) && $stable(core_data_o) && $stable(core_dec_o))); // R11
    AST_OPS_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (busy && !core_req_o && !core_rsp_valid_i) |=>
        ($stable(core_key_o) && $stable(core_data_o) && $stable(core_dec_o))); // R11

endmodule

bind tkey_pass_seq tkey_pass_seq_chk #(.DW(DW), .KW(KW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .core_req_o       (core_req_o),
    .core_dec_o       (core_dec_o),
    .core_key_o       (core_key_o),
    .core_data_o      (core_data_o),
    .core_rsp_valid_i (core_rsp_valid_i),
    .result_o         (result_o),
    .done_o           (done_o),
    .busy             (busy),
    .pass_idx         (pass_idx),
    .run_dec          (run_dec)
);

// File: tb/sim_tkey_pass_seq.sv
module sim_tkey_pass_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        decrypt_i;
    logic [1:0]  key_mode_i;
    logic [63:0] key1_i, key2_i, key3_i, data_i;
    logic        core_req_o, core_dec_o;
    logic [63:0] core_key_o, core_data_o;
    logic        core_rsp_valid_i;
    logic [63:0] core_rsp_data_i;
    logic [63:0] result_o;
    logic        done_o;

    always #4 clk = ~clk;

    tkey_pass_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
        .key_mode_i(key_mode_i), .key1_i(key1_i), .key2_i(key2_i), .key3_i(key3_i),
        .data_i(data_i), .core_req_o(core_req_o), .core_dec_o(core_dec_o),
        .core_key_o(core_key_o), .core_data_o(core_data_o),
        .core_rsp_valid_i(core_rsp_valid_i), .core_rsp_data_i(core_rsp_data_i),
        .result_o(result_o), .done_o(done_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Stand-in core: keyed rotate/add, reversible
    function automatic logic [63:0] core_f(input logic [63:0] x, input logic [63:0] k, input logic dec);
        logic [63:0] t;
        if (!dec) begin
            t = x ^ k;
            return {t[56:0], t[63:57]} + k;
        end
        t = x - k;
        t = {t[6:0], t[63:7]};
        return t ^ k;
    endfunction

    // Reference state for the block in progress
    logic [63:0] rk [3];
    logic        rd [3];
    logic [63:0] rin [4];
    string       key_tag;
    int          pass_seen = 0;
    int          done_seen = 0;
    int          req_total = 0;
    logic [63:0] last_result = '0;

    // Core model state
    int          cnt = 0;
    int          lat = 1;
    logic [63:0] h_key, h_data;
    logic        h_dec;
    bit          final_prev = 0;
    bit          stray_req = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(done_o == final_prev, "R8", "done timing", 64'(done_o), 64'(final_prev));
            if (done_o) begin
                check(result_o == rin[3], "R7", "chained result", result_o, rin[3]);
                check(pass_seen == 3, "R2", "requests per block", 64'(pass_seen), 64'd3);
                last_result = result_o;
                done_seen++;
            end else begin
                check(result_o == last_result, "R8", "result hold", result_o, last_result);
            end
            final_prev = 0;
            core_rsp_valid_i = 1'b0;
            if (core_req_o) begin
                check(cnt == 0, "R2", "request while pass pending", 64'(cnt), 64'd0);
                if (pass_seen < 3) begin
                    check(core_key_o == rk[pass_seen], key_tag, "pass key", core_key_o, rk[pass_seen]);
                    check(core_dec_o == rd[pass_seen], "R3", "pass direction", 64'(core_dec_o), 64'(rd[pass_seen]));
                    check(core_data_o == rin[pass_seen], "R7", "pass input", core_data_o, rin[pass_seen]);
                end else begin
                    check(1'b0, "R2", "extra request", 64'(pass_seen), 64'd2);
                end
                h_key = core_key_o; h_data = core_data_o; h_dec = core_dec_o;
                cnt = lat;
                pass_seen++;
                req_total++;
                lat = 1 + (req_total % 3);
            end else if (cnt > 0) begin
                check(core_key_o == h_key && core_data_o == h_data && core_dec_o == h_dec,
                      "R11", "operands held", core_data_o, h_data);
                cnt--;
                if (cnt == 0) begin
                    core_rsp_valid_i = 1'b1;
                    core_rsp_data_i  = core_f(h_data, h_key, h_dec);
                    final_prev = (pass_seen == 3);
                end
            end else if (stray_req) begin
                stray_req = 0;
                core_rsp_valid_i = 1'b1;
                core_rsp_data_i  = 64'hBAD0_BAD0_BAD0_BAD0;
            end
        end
    end

    task automatic run_job(input logic [1:0] mode, input logic dec,
                           input logic [63:0] k1, input logic [63:0] k2, input logic [63:0] k3,
                           input logic [63:0] d, input bit poke, output logic [63:0] res);
        int d0;
        int r0;
        @(posedge clk);
        #1;
        case (mode)
            2'b00: begin rk[0] = k1; rk[1] = k1; rk[2] = k1; key_tag = "R6"; end
            2'b01: begin rk[0] = k1; rk[1] = k2; rk[2] = k1; key_tag = "R5"; end
            default: begin
                if (dec) begin rk[0] = k3; rk[1] = k2; rk[2] = k1; end
                else     begin rk[0] = k1; rk[1] = k2; rk[2] = k3; end
                key_tag = "R4";
            end
        endcase
        rd[0] = dec; rd[1] = !dec; rd[2] = dec;
        rin[0] = d;
        for (int p = 0; p < 3; p++) rin[p+1] = core_f(rin[p], rk[p], rd[p]);
        pass_seen = 0;
        d0 = done_seen;
        r0 = req_total;
        @(negedge clk);
        start_i = 1'b1; decrypt_i = dec; key_mode_i = mode;
        key1_i = k1; key2_i = k2; key3_i = k3; data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start_i = 1'b1; decrypt_i = !dec; key_mode_i = 2'b00;
            key1_i = ~k1; key2_i = ~k2; key3_i = ~k3; data_i = ~d;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int w = 0; w < 400; w++) begin
            @(posedge clk);
            if (done_seen > d0) break;
        end
        check(done_seen == d0 + 1, "R2", "block completed", 64'(done_seen - d0), 64'd1);
        res = result_o;
        if (poke) begin
            repeat (20) @(posedge clk);
            check(done_seen == d0 + 1 && req_total == r0 + 3, "R9",
                  "start while busy ignored", 64'(req_total - r0), 64'd3);
            check(res == rin[3], "R9", "result unaffected by mid-run input changes", res, rin[3]);
        end
    endtask

    logic [63:0] r_a, r_b;

    initial begin
        rst = 1'b1; start_i = 1'b0; decrypt_i = 1'b0; key_mode_i = 2'b00;
        key1_i = '0; key2_i = '0; key3_i = '0; data_i = '0;
        core_rsp_valid_i = 1'b0; core_rsp_data_i = '0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
        check(core_req_o == 1'b0, "R1", "request after reset", 64'(core_req_o), 64'd0);
        check(result_o == 64'd0, "R1", "result after reset", result_o, 64'd0);

        // R4 three keys, round trip
        run_job(2'b10, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                64'h1357_9BDF_0246_8ACE, 64'h4E6F_7720_6973_2074, 1'b0, r_a);
        run_job(2'b10, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                64'h1357_9BDF_0246_8ACE, r_a, 1'b0, r_b);
        check(r_b == 64'h4E6F_7720_6973_2074, "R4", "three-key round trip", r_b, 64'h4E6F_7720_6973_2074);

        // R5 two keys, round trip
        run_job(2'b01, 1'b0, 64'hA5A5_0F0F_3C3C_9696, 64'h1111_2222_3333_4444,
                64'hDEAD_BEEF_DEAD_BEEF, 64'h0000_0000_0000_0001, 1'b0, r_a);
        run_job(2'b01, 1'b1, 64'hA5A5_0F0F_3C3C_9696, 64'h1111_2222_3333_4444,
                64'h7777_7777_7777_7777, r_a, 1'b0, r_b);
        check(r_b == 64'h1, "R5", "two-key round trip", r_b, 64'h1);

        // R6 one key equals a single pass
        run_job(2'b00, 1'b0, 64'hC0FF_EE00_1234_5678, 64'h5555_5555_5555_5555,
                64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, r_a);
        check(r_a == core_f(64'hFFFF_FFFF_FFFF_FFFF, 64'hC0FF_EE00_1234_5678, 1'b0),
              "R6", "one-key encrypt", r_a, core_f(64'hFFFF_FFFF_FFFF_FFFF, 64'hC0FF_EE00_1234_5678, 1'b0));
        run_job(2'b00, 1'b1, 64'hC0FF_EE00_1234_5678, 64'h5555_5555_5555_5555,
                64'hAAAA_AAAA_AAAA_AAAA, 64'h8000_0000_0000_0000, 1'b0, r_a);
        check(r_a == core_f(64'h8000_0000_0000_0000, 64'hC0FF_EE00_1234_5678, 1'b1),
              "R6", "one-key decrypt", r_a, core_f(64'h8000_0000_0000_0000, 64'hC0FF_EE00_1234_5678, 1'b1));

        // R4 alternate three-key code 2'b11
        run_job(2'b11, 1'b0, 64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0,
                64'h0001_0203_0405_0607, 64'h2468_ACE0_1357_9BDF, 1'b0, r_a);

        // R9 start and input changes during a block
        run_job(2'b10, 1'b1, 64'h3141_5926_5358_9793, 64'h2718_2818_2845_9045,
                64'h1414_2135_6237_3095, 64'h6666_0000_9999_FFFF, 1'b1, r_a);

        // R10 stray response while idle
        @(posedge clk);
        #1 stray_req = 1;
        repeat (6) @(posedge clk);
        check(result_o == last_result, "R10", "stray response ignored", result_o, last_result);
        check(done_o == 1'b0, "R10", "no done from stray response", 64'(done_o), 64'd0);
        run_job(2'b01, 1'b1, 64'hFACE_CAFE_BEAD_F00D, 64'h0BAD_F00D_0BAD_F00D,
                64'h0, 64'h1234_0000_5678_0000, 1'b0, r_a);

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule